// File: doc/BRIEF.md
# Bus Target Transaction Controller

This block is the control core for the target side of a 32-bit PCI bus interface. It watches the initiator's framing and ready strobes, together with the command code on the command/byte-enable lines, during the address phase. It uses an address-range hit or a configuration select, supplied by the decode logic around it, to decide whether to claim the transaction. The claim is made with medium decode timing: the device-select response appears on the second clock after the address phase.

Once a transaction is claimed, the controller drives the active-low device-select, target-ready and stop responses. It gives the user logic a one-cycle address strobe and a strobe for each completed read or write data phase. Four request inputs from the user logic shape each data phase: ready, retry, disconnect and abort. With them the user logic can stream zero-wait bursts, insert wait states, or end the transaction in one of three ways. The state register is a one-hot vector.

Top module: `pci_tgt_fsm`

## Requirements
- R1: While reset is applied and afterwards with the bus idle, `devsel_n`, `trdy_n` and `stop_n` are 1 and all three strobes are 0. The state register has exactly one bit set at all times.
- R2: An address phase is a clock where `frame_n` is sampled 0 after being sampled 1 while the block is idle. For a claimed command, `addr_strobe` is 1 in the next cycle while `devsel_n` is still 1, and `devsel_n` goes to 0 in the cycle after that.
- R3: The commands claimed are 0010, 0011, 0110, 0111, 1100, 1110 and 1111 when `bar_hit` is 1, and 1010 and 1011 when `cfg_sel` is 1. A claimable code without its matching select is not claimed.
- R4: Codes 0001, 0100, 0101, 1000, 1001 and 1101 are never claimed, whatever the selects are: no `devsel_n` low, no strobes. The block then waits for `frame_n` and `irdy_n` both at 1 before it watches for a new address phase.
- R5: A data phase completes only on a clock where `irdy_n` and `trdy_n` are both 0. At that clock `rd_strobe` is 1 for the codes 0010, 0110, 1010, 1100 and 1110, and `wr_strobe` is 1 for 0011, 0111, 1011 and 1111 (write-and-invalidate acts as a plain write).
- R6: With `usr_ready` at 1, `trdy_n` goes low together with `devsel_n` and stays low across consecutive phases, so one phase completes on every clock.
- R7: While `usr_ready` is 0, `trdy_n` stays 1. Once `trdy_n` is 0 it stays 0 until the phase completes, including while `irdy_n` is 1.
- R8: `usr_retry` at the first data phase gives `stop_n`=0, `trdy_n`=1 and `devsel_n`=0 in the cycle where the claim would have started.
- R9: `usr_disc` with `usr_ready` at 1 drives `stop_n` and `trdy_n` low together. With `usr_ready` at 0 it drives `stop_n` low with `trdy_n` at 1 after a completed phase.
- R10: `usr_abort` gives `devsel_n`=1, `stop_n`=0 and `trdy_n`=1.
- R11: Once asserted, `stop_n` stays 0 while `frame_n` is sampled 0. In the cycle after `frame_n` is sampled 1, all three responses are 1.
- R12: A completed phase with `frame_n` at 1 ends the transaction: in the next cycle `devsel_n`, `trdy_n` and `stop_n` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Initiator framing strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cmd_be | input | 4 | Command code in the address phase |
| bar_hit | input | 1 | Address falls in one of the device's memory or I/O ranges |
| cfg_sel | input | 1 | Configuration select for this device |
| usr_ready | input | 1 | User logic can complete the next data phase |
| usr_retry | input | 1 | User logic asks for a retry |
| usr_disc | input | 1 | User logic asks for a disconnect |
| usr_abort | input | 1 | User logic asks for a target abort |
| devsel_n | output | 1 | Device-select response, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| addr_strobe | output | 1 | One-cycle pulse after a claimed address phase |
| rd_strobe | output | 1 | A read data phase completes at this clock |
| wr_strobe | output | 1 | A write data phase completes at this clock |

## Verification
Single-phase transfers are tried across claimed, ignored and mis-selected codes. They separate the claim table from the select-source rule and from medium-versus-fast claim timing. A four-phase read burst separates zero-wait streaming from per-phase handshaking. A transfer with wait states on both sides shows whether target-ready is held during an initiator stall. Retry, disconnect with and without data, and abort are each driven on their own. Together they separate the three stop encodings and show that stop is held until framing ends.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam int CMD_W = 4;
    localparam int ST_W  = 5;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 5'b00001,
        ST_DEC  = 5'b00010,
        ST_IGN  = 5'b00100,
        ST_DATA = 5'b01000,
        ST_TERM = 5'b10000
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e st;
        logic       devsel;
        logic       trdy;
        logic       stop;
        logic       frm_prev;
        logic       claim;
        logic       wr;
        logic       first;
    } tgt_regs_t;

    localparam tgt_regs_t TGT_RESET = '{
        st:       ST_IDLE,
        devsel:   1'b0,
        trdy:     1'b0,
        stop:     1'b0,
        frm_prev: 1'b1,
        claim:    1'b0,
        wr:       1'b0,
        first:    1'b0
    };

endpackage

// File: rtl/pci_tgt_cmd_decode.sv
module pci_tgt_cmd_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [(1<<CMD_W)-1:0] CLAIM_MASK = 16'hDCCC,
    parameter logic [(1<<CMD_W)-1:0] WRITE_MASK = 16'h8888,
    parameter logic [(1<<CMD_W)-1:0] CFG_MASK   = 16'h0C00
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             bar_hit,
    input  logic             cfg_sel,
    output logic             claim,
    output logic             is_wr
);

    logic supported;
    logic sel_ok;

    // Claimable codes are qualified by the select that belongs to them.
    always_comb begin
        supported = CLAIM_MASK[cmd];
        sel_ok    = CFG_MASK[cmd] ? cfg_sel : bar_hit;
        claim     = supported && sel_ok;
        is_wr     = WRITE_MASK[cmd];
    end

endmodule

// File: rtl/pci_tgt_term_sel.sv
module pci_tgt_term_sel (
    input  logic first,
    input  logic ready,
    input  logic retry,
    input  logic disc,
    input  logic abort,
    output logic go_term,
    output logic devsel,
    output logic trdy,
    output logic stop
);

    // Priority: abort, then retry on the first phase, then disconnect,
    // then an ordinary phase paced by the user ready input.
    always_comb begin
        go_term = 1'b0;
        devsel  = 1'b1;
        trdy    = ready;
        stop    = 1'b0;
        if (abort) begin
            go_term = 1'b1;
            devsel  = 1'b0;
            trdy    = 1'b0;
            stop    = 1'b1;
        end else if (retry && first) begin
            go_term = 1'b1;
            trdy    = 1'b0;
            stop    = 1'b1;
        end else if (disc || retry) begin
            go_term = 1'b1;
            stop    = 1'b1;
        end
    end

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
#(
    parameter logic [(1<<CMD_W)-1:0] CLAIM_MASK = 16'hDCCC,
    parameter logic [(1<<CMD_W)-1:0] WRITE_MASK = 16'h8888,
    parameter logic [(1<<CMD_W)-1:0] CFG_MASK   = 16'h0C00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [CMD_W-1:0] cmd_be,
    input  logic             bar_hit,
    input  logic             cfg_sel,
    input  logic             usr_ready,
    input  logic             usr_retry,
    input  logic             usr_disc,
    input  logic             usr_abort,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic             addr_strobe,
    output logic             rd_strobe,
    output logic             wr_strobe
);

    tgt_regs_t cur_q;
    tgt_regs_t nxt_d;

    logic       dec_claim;
    logic       dec_wr;
    logic       xfer;
    logic       sel_first;
    logic       sel_term;
    logic       sel_devsel;
    logic       sel_trdy;
    logic       sel_stop;
    logic [ST_W-1:0] st_now;

    pci_tgt_cmd_decode #(
        .CLAIM_MASK (CLAIM_MASK),
        .WRITE_MASK (WRITE_MASK),
        .CFG_MASK   (CFG_MASK)
    ) u_dec (
        .cmd     (cmd_be),
        .bar_hit (bar_hit),
        .cfg_sel (cfg_sel),
        .claim   (dec_claim),
        .is_wr   (dec_wr)
    );

    pci_tgt_term_sel u_term (
        .first   (sel_first),
        .ready   (usr_ready),
        .retry   (usr_retry),
        .disc    (usr_disc),
        .abort   (usr_abort),
        .go_term (sel_term),
        .devsel  (sel_devsel),
        .trdy    (sel_trdy),
        .stop    (sel_stop)
    );

    // A data phase completes when both ready strobes are low together.
    assign xfer      = cur_q.trdy && !irdy_n;
    assign sel_first = cur_q.first && !xfer;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.frm_prev = frame_n;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (!frame_n && cur_q.frm_prev) begin
                    nxt_d.st    = ST_DEC;
                    nxt_d.claim = dec_claim;
                    nxt_d.wr    = dec_wr;
                    nxt_d.first = 1'b1;
                end
            end
            ST_DEC: begin
                if (cur_q.claim) begin
                    nxt_d.st     = sel_term ? ST_TERM : ST_DATA;
                    nxt_d.devsel = sel_devsel;
                    nxt_d.trdy   = sel_trdy;
                    nxt_d.stop   = sel_stop;
                end else begin
                    nxt_d.st = ST_IGN;
                end
            end
            ST_IGN: begin
                if (frame_n && irdy_n) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (xfer && frame_n) begin
                    nxt_d.st     = ST_IDLE;
                    nxt_d.devsel = 1'b0;
                    nxt_d.trdy   = 1'b0;
                    nxt_d.stop   = 1'b0;
                    nxt_d.claim  = 1'b0;
                end else if (!(cur_q.trdy && !xfer)) begin
                    nxt_d.first  = sel_first;
                    nxt_d.st     = sel_term ? ST_TERM : ST_DATA;
                    nxt_d.devsel = sel_devsel;
                    nxt_d.trdy   = sel_trdy;
                    nxt_d.stop   = sel_stop;
                end
            end
            ST_TERM: begin
                if (frame_n) begin
                    nxt_d.st     = ST_IDLE;
                    nxt_d.devsel = 1'b0;
                    nxt_d.trdy   = 1'b0;
                    nxt_d.stop   = 1'b0;
                    nxt_d.claim  = 1'b0;
                end else if (xfer) begin
                    nxt_d.trdy  = 1'b0;
                    nxt_d.first = 1'b0;
                end
            end
            default: begin
                nxt_d          = TGT_RESET;
                nxt_d.frm_prev = frame_n;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= TGT_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_now      = cur_q.st;
    assign devsel_n    = !cur_q.devsel;
    assign trdy_n      = !cur_q.trdy;
    assign stop_n      = !cur_q.stop;
    assign addr_strobe = (cur_q.st == ST_DEC) && cur_q.claim;
    assign rd_strobe   = xfer && !cur_q.wr;
    assign wr_strobe   = xfer && cur_q.wr;

endmodule

// File: rtl/pci_tgt_fsm_chk.sv
module pci_tgt_fsm_chk
    import pci_tgt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            frame_n,
    input logic            irdy_n,
    input logic            devsel_n,
    input logic            trdy_n,
    input logic            stop_n,
    input logic            addr_strobe,
    input logic            rd_strobe,
    input logic            wr_strobe,
    input logic [ST_W-1:0] st
);

    // R1
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st) == 1);

    // R2
    medium_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && $past(devsel_n)) |-> $past(addr_strobe));

    // R5
    strobe_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> (!irdy_n && !trdy_n));

    // R5
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R7
    trdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n && !frame_n) |=> !trdy_n);

    // R10
    abort_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && devsel_n) |-> trdy_n);

    // R11
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !frame_n) |=> !stop_n);

    // R12
    final_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && stop_n));

endmodule

bind pci_tgt_fsm pci_tgt_fsm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .devsel_n    (devsel_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .addr_strobe (addr_strobe),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .st          (st_now)
);

// File: tb/pci_tgt_fsm_tb.sv
`timescale 1ns/1ps
module pci_tgt_fsm_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_n, irdy_n;
    logic [3:0] cmd_be;
    logic       bar_hit, cfg_sel;
    logic       usr_ready, usr_retry, usr_disc, usr_abort;
    logic       devsel_n, trdy_n, stop_n;
    logic       addr_strobe, rd_strobe, wr_strobe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pci_tgt_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cmd_be(cmd_be), .bar_hit(bar_hit), .cfg_sel(cfg_sel),
        .usr_ready(usr_ready), .usr_retry(usr_retry), .usr_disc(usr_disc),
        .usr_abort(usr_abort), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .addr_strobe(addr_strobe), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        frame_n = 1; irdy_n = 1; bar_hit = 0; cfg_sel = 0;
        usr_ready = 0; usr_retry = 0; usr_disc = 0; usr_abort = 0;
        cmd_be = 4'h0;
    endtask

    task automatic chk_released(input string tag);
        chk({tag, " devsel_n"}, devsel_n, 1);
        chk({tag, " trdy_n"}, trdy_n, 1);
        chk({tag, " stop_n"}, stop_n, 1);
    endtask

    task automatic addr_phase(input logic [3:0] cmd, input logic bar, input logic cfg);
        frame_n = 0; irdy_n = 1; cmd_be = cmd; bar_hit = bar; cfg_sel = cfg;
        cyc();
        bar_hit = 0; cfg_sel = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        bus_idle();
        cyc(); cyc();
        chk_released("R1 in reset");
        rst_n = 1;
        cyc(); cyc();
        chk_released("R1 after reset");
        chk("R1 strobes", {addr_strobe, rd_strobe, wr_strobe}, 0);
    endtask

    task automatic t_single(input logic [3:0] cmd, input logic bar, input logic cfg,
                            input bit exp_claim, input bit exp_wr, input string tag);
        addr_phase(cmd, bar, cfg);
        chk({tag, " R2 addr_strobe"}, addr_strobe, exp_claim);
        chk({tag, " R2 devsel_n not fast"}, devsel_n, 1);
        frame_n = 1; irdy_n = 0; usr_ready = 1;
        cyc();
        chk({tag, " R2 devsel_n"}, devsel_n, !exp_claim);
        chk({tag, " R5 rd_strobe"}, rd_strobe, exp_claim && !exp_wr);
        chk({tag, " R5 wr_strobe"}, wr_strobe, exp_claim && exp_wr);
        cyc();
        chk_released({tag, " R12"});
        bus_idle();
        cyc();
    endtask

    task automatic t_burst_read();
        addr_phase(4'b0110, 1, 0);
        frame_n = 0; irdy_n = 0; usr_ready = 1;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R6 burst trdy_n", trdy_n, 0);
            chk("R6 burst rd_strobe", rd_strobe, 1);
            if (i == 3) frame_n = 1;
        end
        cyc();
        chk_released("R12 burst end");
        bus_idle();
        cyc();
    endtask

    task automatic t_waits();
        addr_phase(4'b0111, 1, 0);
        frame_n = 0; irdy_n = 0; usr_ready = 0;
        cyc();
        chk("R7 claimed", devsel_n, 0);
        chk("R7 not ready trdy_n", trdy_n, 1);
        chk("R7 no wr_strobe", wr_strobe, 0);
        usr_ready = 1;
        cyc();
        chk("R7 ready trdy_n", trdy_n, 0);
        chk("R7 wr_strobe", wr_strobe, 1);
        irdy_n = 1; usr_ready = 0;
        cyc();
        chk("R7 trdy held", trdy_n, 0);
        chk("R7 stall no strobe", wr_strobe, 0);
        irdy_n = 0; frame_n = 1;
        #1;
        chk("R5 final wr_strobe", wr_strobe, 1);
        cyc();
        chk_released("R12 after waits");
        bus_idle();
        cyc();
    endtask

    task automatic t_retry();
        addr_phase(4'b0110, 1, 0);
        frame_n = 0; irdy_n = 0; usr_retry = 1;
        cyc();
        chk("R8 devsel_n", devsel_n, 0);
        chk("R8 stop_n", stop_n, 0);
        chk("R8 trdy_n", trdy_n, 1);
        cyc();
        chk("R11 stop held", stop_n, 0);
        frame_n = 1;
        cyc();
        chk_released("R11 release");
        bus_idle();
        cyc();
    endtask

    task automatic t_abort();
        addr_phase(4'b0011, 1, 0);
        frame_n = 0; irdy_n = 0; usr_abort = 1;
        cyc();
        chk("R10 devsel_n", devsel_n, 1);
        chk("R10 stop_n", stop_n, 0);
        chk("R10 trdy_n", trdy_n, 1);
        frame_n = 1;
        cyc();
        chk_released("R11 after abort");
        bus_idle();
        cyc();
    endtask

    task automatic t_disc_data();
        addr_phase(4'b0110, 1, 0);
        frame_n = 0; irdy_n = 0; usr_ready = 1;
        cyc();
        chk("R9 first rd_strobe", rd_strobe, 1);
        usr_disc = 1;
        cyc();
        chk("R9 with data stop_n", stop_n, 0);
        chk("R9 with data trdy_n", trdy_n, 0);
        chk("R9 with data rd_strobe", rd_strobe, 1);
        frame_n = 1;
        cyc();
        chk_released("R11 after disconnect");
        bus_idle();
        cyc();
    endtask

    task automatic t_disc_nodata();
        addr_phase(4'b0111, 1, 0);
        frame_n = 0; irdy_n = 0; usr_ready = 1;
        cyc();
        chk("R9 first wr_strobe", wr_strobe, 1);
        usr_disc = 1; usr_ready = 0;
        cyc();
        chk("R9 no data stop_n", stop_n, 0);
        chk("R9 no data trdy_n", trdy_n, 1);
        chk("R9 no data devsel_n", devsel_n, 0);
        chk("R9 no data wr_strobe", wr_strobe, 0);
        frame_n = 1;
        cyc();
        chk_released("R11 after no-data stop");
        bus_idle();
        cyc();
    endtask

    task automatic t_ignored(input logic [3:0] cmd);
        addr_phase(cmd, 1, 1);
        chk("R4 addr_strobe", addr_strobe, 0);
        irdy_n = 0; usr_ready = 1;
        cyc();
        chk("R4 devsel_n", devsel_n, 1);
        chk("R4 strobes", {rd_strobe, wr_strobe}, 0);
        cyc();
        chk("R4 devsel_n later", devsel_n, 1);
        frame_n = 1;
        cyc();
        chk("R4 devsel_n last", devsel_n, 1);
        bus_idle();
        cyc();
        t_single(4'b0111, 1, 0, 1, 1, "R4 claim after ignored");
    endtask

    initial begin
        t_reset();
        t_single(4'b0111, 1, 0, 1, 1, "R3 mem write");
        t_single(4'b0110, 1, 0, 1, 0, "R3 mem read");
        t_single(4'b0010, 1, 0, 1, 0, "R3 io read");
        t_single(4'b0011, 1, 0, 1, 1, "R3 io write");
        t_single(4'b1010, 0, 1, 1, 0, "R3 cfg read");
        t_single(4'b1011, 0, 1, 1, 1, "R3 cfg write");
        t_single(4'b1100, 1, 0, 1, 0, "R3 read multiple");
        t_single(4'b1110, 1, 0, 1, 0, "R3 read line");
        t_single(4'b1111, 1, 0, 1, 1, "R5 write invalidate");
        t_single(4'b1010, 1, 0, 0, 0, "R3 cfg without select");
        t_single(4'b0110, 0, 1, 0, 0, "R3 mem without hit");
        t_ignored(4'b0001);
        t_ignored(4'b1101);
        t_ignored(4'b0100);
        t_ignored(4'b0101);
        t_ignored(4'b1000);
        t_ignored(4'b1001);
        t_burst_read();
        t_waits();
        t_retry();
        t_abort();
        t_disc_data();
        t_disc_nodata();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule